// File: doc/BRIEF.md
# Serial Frame Transmitter, 8 data bits, no parity, 2 stop bits

This block turns one byte into an asynchronous serial frame on a single output line. A frame is a low start bit, the eight data bits with the least significant bit first, and two high stop bits. There is no parity bit. The line rests high whenever no frame is being sent. Bit timing comes from an external baud tick, which is a single-cycle pulse once per bit period.

A client presents a byte and pulses the start strobe while `busy` is low. The block takes a copy of the byte and raises `busy`. It then waits in an armed phase for the next baud tick, so the start bit, and every bit after it, begins on a tick edge. Any strobe issued while `busy` is high is ignored. `busy` falls after the second stop bit, and a new request is accepted in the very next cycle.

Top module: `serialFrameTx`

## Requirements
- R1: A frame is 11 bit periods long: one low start bit, eight data bits, and two high stop bits. No parity bit is sent.
- R2: `busy` rises in the cycle after a strobe is accepted. It stays high until the tick that ends the second stop bit, and it is low in the cycle after that tick.
- R3: A strobe seen while idle moves the block to an armed phase, where the line stays high. The tick that follows begins the start bit (line low).
- R4: The block leaves a bit only on a baud tick. The line holds its value for the whole interval between two ticks.
- R5: The data bits go out least significant bit first. Data bit k is on the line during bit period k+1 of the frame, where period 0 is the start bit.
- R6: The line is high after reset, while idle, while armed, and during both stop bits.
- R7: The byte is captured in the cycle the strobe is accepted. Later changes on `dataIn` do not alter the frame.
- R8: A strobe issued while `busy` is high is ignored. The frame in progress is unchanged, and no second frame follows it.
- R9: A strobe issued in the first cycle after `busy` falls is accepted and starts a new frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| baudTick | input | 1 | Single-cycle pulse, once per bit period |
| startReq | input | 1 | Request to send `dataIn`; honoured only when idle |
| dataIn | input | 8 | Byte to send |
| busy | output | 1 | High from acceptance until the second stop bit ends |
| txLine | output | 1 | Serial output; idles high |

## Verification
The assertions assume that `baudTick` is a single-cycle pulse and that ticks are at least a few clocks apart. They also assume that the strobe and data inputs are stable around each clock edge. The bench produces a tick every fifth clock. It drives the strobe and data only on falling edges, and it holds each strobe for exactly one cycle. It sends every byte value. Every third frame carries a strobe with different data in the middle of the frame, and each frame starts in the cycle right after the previous one ends. The bench decodes the line one cycle after each tick and again later in the same bit period.

// File: rtl/serialFrameTx_pkg.sv
package serialFrameTx_pkg;

  // Frame phases; the 3-bit code leaves unused values, which the controller
  // treats as illegal and clears on the next tick.
  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_ARMED = 3'd1,
    PH_START = 3'd2,
    PH_DATA  = 3'd3,
    PH_STOP  = 3'd4
  } phaseT;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;      // capture the input byte
    logic driveLow;  // start bit
    logic driveData; // present the selected data bit
  } ctlT;

endpackage

// File: rtl/serialFrameTxCtrl.sv
module serialFrameTxCtrl
  import serialFrameTx_pkg::*;
#(
  parameter int DATA_BITS = 8,
  parameter int STOP_BITS = 2,
  localparam int CNT_W = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             baudTick,
  input  logic             startReq,
  output ctlT              ctl,
  output logic [CNT_W-1:0] bitSel,
  output logic             busy
);

  localparam logic [CNT_W-1:0] LAST_DATA = CNT_W'(DATA_BITS - 1);
  localparam logic [CNT_W-1:0] LAST_STOP = CNT_W'(STOP_BITS - 1);

  phaseT            phase;
  logic [CNT_W-1:0] bitCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase  <= PH_IDLE;
      bitCnt <= '0;
    end else begin
      case (phase)
        PH_IDLE:  if (startReq) phase <= PH_ARMED;
        PH_ARMED: if (baudTick) phase <= PH_START;
        PH_START: if (baudTick) begin
          phase  <= PH_DATA;
          bitCnt <= '0;
        end
        PH_DATA: if (baudTick) begin
          if (bitCnt == LAST_DATA) begin
            phase  <= PH_STOP;
            bitCnt <= '0;
          end else begin
            bitCnt <= bitCnt + 1'b1;
          end
        end
        PH_STOP: if (baudTick) begin
          if (bitCnt == LAST_STOP) begin
            phase  <= PH_IDLE;
            bitCnt <= '0;
          end else begin
            bitCnt <= bitCnt + 1'b1;
          end
        end
        default: if (baudTick) begin
          phase  <= PH_IDLE;
          bitCnt <= '0;
        end
      endcase
    end
  end

  always_comb begin
    ctl.load      = (phase == PH_IDLE) && startReq;
    ctl.driveLow  = (phase == PH_START);
    ctl.driveData = (phase == PH_DATA);
    bitSel        = bitCnt;
    busy          = (phase != PH_IDLE);
  end

  assert_arm_on_strobe_R3: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_IDLE && startReq) |=> (phase == PH_ARMED));

  assert_start_on_tick_R3: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_ARMED && baudTick) |=> (phase == PH_START));

  assert_hold_without_tick_R4: assert property (@(posedge clk) disable iff (!rstN)
    (phase != PH_IDLE && !baudTick) |=> ($stable(phase) && $stable(bitCnt)));

  assert_ignore_when_busy_R8: assert property (@(posedge clk) disable iff (!rstN)
    (phase != PH_IDLE && startReq && !baudTick) |=> (phase != PH_ARMED || $past(phase) == PH_ARMED));

endmodule

// File: rtl/serialFrameTxPath.sv
module serialFrameTxPath
  import serialFrameTx_pkg::*;
#(
  parameter int DATA_BITS = 8,
  localparam int CNT_W = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctlT                  ctl,
  input  logic [CNT_W-1:0]     bitSel,
  input  logic [DATA_BITS-1:0] dataIn,
  output logic                 txLine
);

  logic [DATA_BITS-1:0] dataReg;

  always_ff @(posedge clk) begin
    if (!rstN)         dataReg <= '0;
    else if (ctl.load) dataReg <= dataIn;
  end

  always_comb begin
    if (ctl.driveLow)       txLine = 1'b0;
    else if (ctl.driveData) txLine = dataReg[bitSel];
    else                    txLine = 1'b1;
  end

  assert_capture_frozen_R7: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.load |=> $stable(dataReg));

  assert_strobes_exclusive_R1: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctl.driveLow, ctl.driveData}));

endmodule

// File: rtl/serialFrameTx.sv
module serialFrameTx
  import serialFrameTx_pkg::*;
#(
  parameter int DATA_BITS = 8,
  parameter int STOP_BITS = 2,
  localparam int CNT_W = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 baudTick,
  input  logic                 startReq,
  input  logic [DATA_BITS-1:0] dataIn,
  output logic                 busy,
  output logic                 txLine
);

  ctlT              ctl;
  logic [CNT_W-1:0] bitSel;

  serialFrameTxCtrl #(.DATA_BITS(DATA_BITS), .STOP_BITS(STOP_BITS)) ctrl_i (
    .clk(clk), .rstN(rstN), .baudTick(baudTick), .startReq(startReq),
    .ctl(ctl), .bitSel(bitSel), .busy(busy)
  );

  serialFrameTxPath #(.DATA_BITS(DATA_BITS)) path_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .bitSel(bitSel),
    .dataIn(dataIn), .txLine(txLine)
  );

  assert_idle_line_high_R6: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> txLine);

  assert_busy_from_strobe_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(startReq));

  assert_busy_ends_on_tick_R2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> $past(baudTick));

endmodule

// File: tb/serialFrameTx_tb_top.sv
module serialFrameTx_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 5;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       startReq = 1'b0;
  logic [7:0] dataIn = 8'h00;
  logic       busy;
  logic       txLine;
  logic       baudTick;
  int         tickCnt = 0;
  int         tests = 0;
  int         fails = 0;
  bit         done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  // Tick generator: updated on falling edges, so it is stable at each rising edge
  always @(negedge clk) tickCnt = (tickCnt == TICK_DIV - 1) ? 0 : tickCnt + 1;
  assign baudTick = (tickCnt == TICK_DIV - 1);

  serialFrameTx dut_i (
    .clk(clk), .rstN(rstN), .baudTick(baudTick), .startReq(startReq),
    .dataIn(dataIn), .busy(busy), .txLine(txLine)
  );

  task automatic check(input logic got, input logic exp, input string tag);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: actual %0b expected %0b", tag, got, exp);
    end
  endtask

  // Return at the falling edge that follows the next rising edge with a tick
  task automatic waitTick();
    @(posedge clk);
    while (!baudTick) @(posedge clk);
    @(negedge clk);
  endtask

  // Called at a falling edge; returns at the falling edge after the end-of-frame tick
  task automatic sendFrame(input logic [7:0] b, input bit poke);
    logic expBit;
    startReq = 1'b1;
    dataIn   = b;
    @(negedge clk);
    startReq = 1'b0;
    dataIn   = ~b;
    check(busy, 1'b1, "R2/R9 busy after accept");
    check(txLine, 1'b1, "R3/R6 armed line high");
    for (int k = 0; k < 11; k++) begin
      waitTick();
      if (k == 0)      expBit = 1'b0;
      else if (k <= 8) expBit = b[k-1];
      else             expBit = 1'b1;
      check(txLine, expBit, (k == 0) ? "R1/R3 start bit" :
                            (k <= 8) ? "R5/R7 data bit" : "R1/R6 stop bit");
      check(busy, 1'b1, "R2 busy during frame");
      if (poke && k == 4) begin
        startReq = 1'b1;
        dataIn   = 8'hA5;
        @(negedge clk);
        startReq = 1'b0;
      end
      @(negedge clk);
      @(negedge clk);
      check(txLine, expBit, "R4 bit held between ticks");
    end
    waitTick();
    check(busy, 1'b0, "R2 busy low after last stop");
    check(txLine, 1'b1, "R6 idle line high");
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (6) @(negedge clk);
    check(busy, 1'b0, "R2 reset busy");
    check(txLine, 1'b1, "R6 reset line");
    rstN = 1'b1;
    @(negedge clk);
    // every byte, back to back (R9), with busy-time strobes on some (R8)
    for (int v = 0; v < 256; v++) sendFrame(8'(v), (v % 3) == 0);
    // strobe while busy must not start a second frame
    sendFrame(8'h3C, 1'b1);
    for (int t = 0; t < 3; t++) begin
      waitTick();
      check(busy, 1'b0, "R8 no frame from busy strobe");
      check(txLine, 1'b1, "R8 line stays idle");
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule